// File: doc/BRIEF.md
# Flash Erase-Verify Command Front End

This block receives erase-verify commands for a flash memory that holds two regions, a program region and a data region. Software loads a parameter index and a parameter word through a small register write interface. It then launches the command by writing a one to the command-complete flag, which clears that flag. The block checks the launch conditions and rejects bad commands through an access-error flag. An accepted command reads the selected words through one synchronous read port for each region and reports a two-bit verify status. The command-complete flag goes high again when the scan ends.

Each region port has a one-cycle read latency and returns per-word correctable and uncorrectable error indications. A separate host read path lets the processor read either region. A host read of a region that a running command is scanning returns invalid data (all zeros). If no fault flag is already set, that read raises both fault flags. A host read of an idle region goes through to the array.

Register writes (`wr_addr`): 0 is the status register, where bit 7 is the launch/complete flag, bit 5 is the access-error flag and bit 4 is the protection flag. 1 is the fault register, where bit 1 is the double fault and bit 0 is the single fault. 2 is the parameter index in bits [2:0]. 3 is the parameter word at the current index. In parameter word 0, bits [15:8] hold the command code and bits [1:0] hold global address bits [17:16].

Top module: `fev_ctrl`

## Requirements
- R1: After reset, `done` is 1 and `acc_err`, `prot_err`, `vstat`, `flt_sgl` and `flt_dbl` are all 0.
- R2: A write to address 0 with bit 7 set, made while `done` is 1, with no error flag set, the index at 0 and a valid command, clears `done` and starts a scan. `done` returns to 1 when the scan ends.
- R3: Code 0x01 reads every word of the program region, then every word of the data region. With all words erased, it ends with `vstat` = 00.
- R4: Code 0x02 scans only the program region when bits [1:0] of parameter word 0 are 00, and only the data region when they are 01. Other values of those bits, and any code other than 0x01 and 0x02, set `acc_err` and start nothing.
- R5: A launch with a parameter index other than 000 sets `acc_err`, leaves `done` at 1 and reads no word.
- R6: While `acc_err` or `prot_err` is set, a launch starts nothing and leaves `done` at 1. Writing a one to status bit 5 clears `acc_err`, and writing a one to status bit 4 clears `prot_err`. `prot_err` is set only by the `prot_set` input.
- R7: Running a command never sets `prot_err`.
- R8: `vstat` is cleared at launch. `vstat[1]` is set when any scanned word reports a correctable or an uncorrectable error. `vstat[0]` is set when any scanned word reports an uncorrectable error.
- R9: A word is erased only when all of its bits are 1. The first word that is not erased sets `vstat` to 11 and ends the command. Beyond that word, at most the one word already requested is read, and a later region is not read.
- R10: A host read of a region being scanned returns zero data one cycle later. It sets both fault flags when neither is set and changes neither flag when one is already set. Writing ones to fault register bits 1 and 0 clears the double and single fault flags.
- R11: A host read of a region that no command is scanning returns that region's array word, with `h_rd_valid` high in the following cycle.
- R12: Writes to the index and parameter registers made while a command runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Register write data |
| prot_set | input | 1 | Protection violation report from outside the block |
| h_rd_en | input | 1 | Host read request |
| h_rd_sel | input | 1 | Host read region: 0 program, 1 data |
| h_rd_addr | input | HAW | Host read word address |
| h_rd_valid | output | 1 | Host read data valid |
| h_rd_data | output | DW | Host read data |
| p_rd_en | output | 1 | Program region read enable |
| p_rd_addr | output | PAW | Program region word address |
| p_rd_data | input | DW | Program region read data |
| p_rd_cor | input | 1 | Program word had a corrected error |
| p_rd_unc | input | 1 | Program word had an uncorrectable error |
| d_rd_en | output | 1 | Data region read enable |
| d_rd_addr | output | DAW | Data region word address |
| d_rd_data | input | DW | Data region read data |
| d_rd_cor | input | 1 | Data word had a corrected error |
| d_rd_unc | input | 1 | Data word had an uncorrectable error |
| done | output | 1 | Command-complete flag |
| acc_err | output | 1 | Access error flag |
| prot_err | output | 1 | Protection violation flag |
| vstat | output | 2 | Verify status: bit 1 any error, bit 0 uncorrectable |
| flt_sgl | output | 1 | Single fault flag |
| flt_dbl | output | 1 | Double fault flag |

## Verification
On every cycle, the assertions check the launch gating: `done` falls only on a launch write, and a blocked launch or a launch with a bad index leaves `done` high. They also check that `prot_err` rises only after `prot_set`, that region addresses stay in range, and that host reads are answered one cycle later with zeros when they collide with a scan. The bench scenarios cover the rest. They count the words each command reads from each region and compare the verify status after correctable, uncorrectable and non-erased words. They also check the early stop on a dirty word, the fault-flag rule when only one flag is set, and the register writes that are ignored during a command.

// File: rtl/fev_pkg.sv
package fev_pkg;
   localparam int REGW = 16;
   localparam logic [1:0] A_STAT  = 2'd0;
   localparam logic [1:0] A_FAULT = 2'd1;
   localparam logic [1:0] A_INDEX = 2'd2;
   localparam logic [1:0] A_PARAM = 2'd3;
   localparam int B_LAUNCH = 7;
   localparam int B_ACC    = 5;
   localparam int B_PROT   = 4;
   localparam logic [7:0] OP_VERIFY_ALL = 8'h01;
   localparam logic [7:0] OP_VERIFY_ONE = 8'h02;
   typedef enum logic {RGN_PROG = 1'b0, RGN_DATA = 1'b1} rgn_e;
   typedef enum logic {SC_IDLE = 1'b0, SC_SCAN = 1'b1} scan_e;
endpackage

// File: rtl/fev_cmd_regs.sv
module fev_cmd_regs
   import fev_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [1:0]      wr_addr,
   input  logic [REGW-1:0] wr_data,
   input  logic            prot_set,
   input  logic            fin,
   output logic            start,
   output logic            start_all,
   output rgn_e            start_sel,
   output logic            done,
   output logic            acc_err,
   output logic            prot_err,
   output logic [1:0]      flt_clr,
   output logic [2:0]      cur_idx
);
   logic [7:0] op_q;
   logic [1:0] gsel_q;
   logic       launch_req, blocked, params_ok, stat_wr, acc_set;

   assign stat_wr    = wr_en && (wr_addr == A_STAT);
   assign launch_req = stat_wr && wr_data[B_LAUNCH] && done;
   assign blocked    = acc_err || prot_err;

   always_comb begin
      params_ok = (cur_idx == 3'd0) &&
                  ((op_q == OP_VERIFY_ALL) ||
                   ((op_q == OP_VERIFY_ONE) && (gsel_q <= 2'd1)));
   end

   assign start     = launch_req && !blocked && params_ok;
   assign acc_set   = launch_req && !blocked && !params_ok;
   assign start_all = (op_q == OP_VERIFY_ALL);
   assign start_sel = (gsel_q[0] && (op_q == OP_VERIFY_ONE)) ? RGN_DATA : RGN_PROG;
   assign flt_clr   = (wr_en && (wr_addr == A_FAULT)) ? wr_data[1:0] : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b1;
         acc_err  <= 1'b0;
         prot_err <= 1'b0;
         cur_idx  <= 3'd0;
         op_q     <= 8'd0;
         gsel_q   <= 2'd0;
      end else begin
         if (start)    done <= 1'b0;
         else if (fin) done <= 1'b1;
         acc_err  <= (acc_err && !(stat_wr && wr_data[B_ACC])) || acc_set;
         prot_err <= (prot_err && !(stat_wr && wr_data[B_PROT])) || prot_set;
         if (wr_en && done && (wr_addr == A_INDEX))
            cur_idx <= wr_data[2:0];
         if (wr_en && done && (wr_addr == A_PARAM) && (cur_idx == 3'd0)) begin
            op_q   <= wr_data[15:8];
            gsel_q <= wr_data[1:0];
         end
      end
   end
endmodule

// File: rtl/fev_scanner.sv
module fev_scanner
   import fev_pkg::*;
#(
   parameter int P_WORDS = 16,
   parameter int D_WORDS = 8,
   parameter int DW      = 16,
   localparam int MAXW   = (P_WORDS > D_WORDS) ? P_WORDS : D_WORDS,
   localparam int AW     = $clog2(MAXW),
   localparam int CW     = $clog2(MAXW + 1)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          start_all,
   input  rgn_e          start_sel,
   input  logic [DW-1:0] p_rdata,
   input  logic          p_cor,
   input  logic          p_unc,
   input  logic [DW-1:0] d_rdata,
   input  logic          d_cor,
   input  logic          d_unc,
   output logic          s_p_en,
   output logic          s_d_en,
   output logic [AW-1:0] s_addr,
   output logic          fin,
   output logic [1:0]    vstat,
   output logic          p_busy,
   output logic          d_busy
);
   localparam logic [CW-1:0] P_N = CW'(P_WORDS);
   localparam logic [CW-1:0] D_N = CW'(D_WORDS);

   scan_e         st;
   rgn_e          rsel;
   logic          all_q, pend, last_q;
   logic [CW-1:0] cnt, nwords;
   logic [DW-1:0] w;
   logic          w_cor, w_unc, issue, word_bad, region_end, hop;

   always_comb begin
      nwords = (rsel == RGN_DATA) ? D_N : P_N;
      w      = (rsel == RGN_DATA) ? d_rdata : p_rdata;
      w_cor  = (rsel == RGN_DATA) ? d_cor : p_cor;
      w_unc  = (rsel == RGN_DATA) ? d_unc : p_unc;
   end

   assign issue      = (st == SC_SCAN) && (cnt < nwords);
   assign word_bad   = pend && (w != {DW{1'b1}});
   assign region_end = pend && !word_bad && last_q;
   assign hop        = region_end && all_q && (rsel == RGN_PROG);
   assign fin        = (st == SC_SCAN) && (word_bad || (region_end && !hop));
   assign s_p_en     = issue && (rsel == RGN_PROG);
   assign s_d_en     = issue && (rsel == RGN_DATA);
   assign s_addr     = cnt[AW-1:0];
   assign p_busy     = (st == SC_SCAN) && (all_q || (rsel == RGN_PROG));
   assign d_busy     = (st == SC_SCAN) && (all_q || (rsel == RGN_DATA));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SC_IDLE;
         rsel   <= RGN_PROG;
         all_q  <= 1'b0;
         cnt    <= '0;
         pend   <= 1'b0;
         last_q <= 1'b0;
         vstat  <= 2'b00;
      end else if (start) begin
         st     <= SC_SCAN;
         rsel   <= start_all ? RGN_PROG : start_sel;
         all_q  <= start_all;
         cnt    <= '0;
         pend   <= 1'b0;
         last_q <= 1'b0;
         vstat  <= 2'b00;
      end else if (st == SC_SCAN) begin
         pend   <= issue;
         last_q <= issue && (cnt == nwords - 1'b1);
         if (issue) cnt <= cnt + 1'b1;
         if (pend && (w_cor || w_unc)) vstat[1] <= 1'b1;
         if (pend && w_unc)            vstat[0] <= 1'b1;
         if (word_bad)                 vstat    <= 2'b11;
         if (fin) begin
            st   <= SC_IDLE;
            pend <= 1'b0;
         end else if (hop) begin
            rsel   <= RGN_DATA;
            cnt    <= '0;
            pend   <= 1'b0;
            last_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/fev_host_port.sv
module fev_host_port
   import fev_pkg::*;
#(
   parameter int PAW = 4,
   parameter int DAW = 3,
   parameter int HAW = 4,
   parameter int AW  = 4,
   parameter int DW  = 16
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           h_rd_en,
   input  logic           h_rd_sel,
   input  logic [HAW-1:0] h_rd_addr,
   input  logic           p_busy,
   input  logic           d_busy,
   input  logic           s_p_en,
   input  logic           s_d_en,
   input  logic [AW-1:0]  s_addr,
   input  logic [DW-1:0]  p_rd_data,
   input  logic [DW-1:0]  d_rd_data,
   input  logic [1:0]     flt_clr,
   output logic           p_rd_en,
   output logic [PAW-1:0] p_rd_addr,
   output logic           d_rd_en,
   output logic [DAW-1:0] d_rd_addr,
   output logic           h_rd_valid,
   output logic [DW-1:0]  h_rd_data,
   output logic           flt_sgl,
   output logic           flt_dbl
);
   logic hp_go, hd_go, collide, newf, bad_q, sel_q;

   assign hp_go   = h_rd_en && (h_rd_sel == RGN_PROG) && !p_busy;
   assign hd_go   = h_rd_en && (h_rd_sel == RGN_DATA) && !d_busy;
   assign collide = h_rd_en && ((h_rd_sel == RGN_DATA) ? d_busy : p_busy);
   assign newf    = collide && !flt_sgl && !flt_dbl;

   assign p_rd_en   = s_p_en || hp_go;
   assign d_rd_en   = s_d_en || hd_go;
   assign p_rd_addr = s_p_en ? s_addr[PAW-1:0] : h_rd_addr[PAW-1:0];
   assign d_rd_addr = s_d_en ? s_addr[DAW-1:0] : h_rd_addr[DAW-1:0];

   always_comb begin
      if (!h_rd_valid || bad_q) h_rd_data = '0;
      else                      h_rd_data = sel_q ? d_rd_data : p_rd_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_rd_valid <= 1'b0;
         bad_q      <= 1'b0;
         sel_q      <= 1'b0;
         flt_sgl    <= 1'b0;
         flt_dbl    <= 1'b0;
      end else begin
         h_rd_valid <= h_rd_en;
         bad_q      <= collide;
         sel_q      <= h_rd_sel;
         flt_sgl    <= (flt_sgl && !flt_clr[0]) || newf;
         flt_dbl    <= (flt_dbl && !flt_clr[1]) || newf;
      end
   end
endmodule

// File: rtl/fev_ctrl.sv
module fev_ctrl
   import fev_pkg::*;
#(
   parameter int P_WORDS = 16,
   parameter int D_WORDS = 8,
   parameter int DW      = 16,
   localparam int PAW    = $clog2(P_WORDS),
   localparam int DAW    = $clog2(D_WORDS),
   localparam int HAW    = (PAW > DAW) ? PAW : DAW
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [1:0]      wr_addr,
   input  logic [REGW-1:0] wr_data,
   input  logic            prot_set,
   input  logic            h_rd_en,
   input  logic            h_rd_sel,
   input  logic [HAW-1:0]  h_rd_addr,
   output logic            h_rd_valid,
   output logic [DW-1:0]   h_rd_data,
   output logic            p_rd_en,
   output logic [PAW-1:0]  p_rd_addr,
   input  logic [DW-1:0]   p_rd_data,
   input  logic            p_rd_cor,
   input  logic            p_rd_unc,
   output logic            d_rd_en,
   output logic [DAW-1:0]  d_rd_addr,
   input  logic [DW-1:0]   d_rd_data,
   input  logic            d_rd_cor,
   input  logic            d_rd_unc,
   output logic            done,
   output logic            acc_err,
   output logic            prot_err,
   output logic [1:0]      vstat,
   output logic            flt_sgl,
   output logic            flt_dbl
);
   localparam int AW = HAW;

   generate
      if (P_WORDS < 2) begin : g_bad_p
         $error("fev_ctrl: P_WORDS must be at least 2");
      end
      if (D_WORDS < 2) begin : g_bad_d
         $error("fev_ctrl: D_WORDS must be at least 2");
      end
      if (DW < 1) begin : g_bad_w
         $error("fev_ctrl: DW must be positive");
      end
   endgenerate

   logic          start, start_all, fin, p_busy, d_busy, s_p_en, s_d_en;
   rgn_e          start_sel;
   logic [1:0]    flt_clr;
   logic [2:0]    cur_idx;
   logic [AW-1:0] s_addr;

   fev_cmd_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .prot_set(prot_set), .fin(fin), .start(start),
      .start_all(start_all), .start_sel(start_sel), .done(done),
      .acc_err(acc_err), .prot_err(prot_err), .flt_clr(flt_clr),
      .cur_idx(cur_idx)
   );

   fev_scanner #(.P_WORDS(P_WORDS), .D_WORDS(D_WORDS), .DW(DW)) u_scan (
      .clk(clk), .rst_n(rst_n), .start(start), .start_all(start_all),
      .start_sel(start_sel), .p_rdata(p_rd_data), .p_cor(p_rd_cor),
      .p_unc(p_rd_unc), .d_rdata(d_rd_data), .d_cor(d_rd_cor),
      .d_unc(d_rd_unc), .s_p_en(s_p_en), .s_d_en(s_d_en), .s_addr(s_addr),
      .fin(fin), .vstat(vstat), .p_busy(p_busy), .d_busy(d_busy)
   );

   fev_host_port #(.PAW(PAW), .DAW(DAW), .HAW(HAW), .AW(AW), .DW(DW)) u_host (
      .clk(clk), .rst_n(rst_n), .h_rd_en(h_rd_en), .h_rd_sel(h_rd_sel),
      .h_rd_addr(h_rd_addr), .p_busy(p_busy), .d_busy(d_busy),
      .s_p_en(s_p_en), .s_d_en(s_d_en), .s_addr(s_addr),
      .p_rd_data(p_rd_data), .d_rd_data(d_rd_data), .flt_clr(flt_clr),
      .p_rd_en(p_rd_en), .p_rd_addr(p_rd_addr), .d_rd_en(d_rd_en),
      .d_rd_addr(d_rd_addr), .h_rd_valid(h_rd_valid), .h_rd_data(h_rd_data),
      .flt_sgl(flt_sgl), .flt_dbl(flt_dbl)
   );
endmodule

// File: rtl/fev_ctrl_chk.sv
module fev_ctrl_chk #(
   parameter int P_WORDS = 16,
   parameter int D_WORDS = 8,
   parameter int DW      = 16,
   parameter int PAW     = 4,
   parameter int DAW     = 3
)(
   input logic           clk,
   input logic           rst_n,
   input logic           wr_en,
   input logic [1:0]     wr_addr,
   input logic [15:0]    wr_data,
   input logic           prot_set,
   input logic           h_rd_en,
   input logic           h_rd_sel,
   input logic           h_rd_valid,
   input logic [DW-1:0]  h_rd_data,
   input logic           p_rd_en,
   input logic [PAW-1:0] p_rd_addr,
   input logic           d_rd_en,
   input logic [DAW-1:0] d_rd_addr,
   input logic           done,
   input logic           acc_err,
   input logic           prot_err,
   input logic           p_busy,
   input logic           d_busy,
   input logic [2:0]     cur_idx
);
   logic launch_wr;
   assign launch_wr = wr_en && (wr_addr == 2'd0) && wr_data[7];

   // R2
   done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done) |-> $past(launch_wr));

   // R5
   bad_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_wr && done && !acc_err && !prot_err && (cur_idx != 3'd0))
      |=> (acc_err && done));

   // R6
   blocked_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_wr && (acc_err || prot_err)) |=> done);

   // R7
   prot_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prot_err) |-> $past(prot_set));

   // R10
   busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (h_rd_en && (h_rd_sel ? d_busy : p_busy)) |=> (h_rd_valid && (h_rd_data == '0)));

   // R11
   read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      h_rd_en |=> h_rd_valid);

   // R3
   p_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      p_rd_en |-> (32'(p_rd_addr) < P_WORDS));

   // R3
   d_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      d_rd_en |-> (32'(d_rd_addr) < D_WORDS));
endmodule

bind fev_ctrl fev_ctrl_chk #(
   .P_WORDS(P_WORDS), .D_WORDS(D_WORDS), .DW(DW), .PAW(PAW), .DAW(DAW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .prot_set(prot_set), .h_rd_en(h_rd_en),
   .h_rd_sel(h_rd_sel), .h_rd_valid(h_rd_valid), .h_rd_data(h_rd_data),
   .p_rd_en(p_rd_en), .p_rd_addr(p_rd_addr), .d_rd_en(d_rd_en),
   .d_rd_addr(d_rd_addr), .done(done), .acc_err(acc_err),
   .prot_err(prot_err), .p_busy(p_busy), .d_busy(d_busy), .cur_idx(cur_idx)
);

// File: tb/sim_fev_ctrl.sv
module sim_fev_ctrl;
   localparam int PW = 16;
   localparam int DWD = 8;
   localparam int W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic prot_set = 1'b0;
   logic h_rd_en = 1'b0;
   logic h_rd_sel = 1'b0;
   logic [3:0] h_rd_addr = '0;
   logic h_rd_valid;
   logic [W-1:0] h_rd_data;
   logic p_rd_en, d_rd_en;
   logic [3:0] p_rd_addr;
   logic [2:0] d_rd_addr;
   logic [W-1:0] p_q, d_q;
   logic pc_q, pu_q, dc_q, du_q;
   logic done, acc_err, prot_err, flt_sgl, flt_dbl;
   logic [1:0] vstat;

   logic [W-1:0] p_mem [PW];
   logic [W-1:0] d_mem [DWD];
   logic p_cor [PW];
   logic p_unc [PW];
   logic d_cor [DWD];
   logic d_unc [DWD];

   int checks = 0;
   int fails = 0;
   int p_reads = 0;
   int d_reads = 0;
   logic done_q = 1'b1;

   typedef struct {
      logic [1:0] vs;
      int pr;
      int dr;
      int pb;
      int db;
      string req;
   } exp_t;
   exp_t expq[$];

   always #10 clk = ~clk;

   fev_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .prot_set(prot_set), .h_rd_en(h_rd_en),
      .h_rd_sel(h_rd_sel), .h_rd_addr(h_rd_addr), .h_rd_valid(h_rd_valid),
      .h_rd_data(h_rd_data), .p_rd_en(p_rd_en), .p_rd_addr(p_rd_addr),
      .p_rd_data(p_q), .p_rd_cor(pc_q), .p_rd_unc(pu_q), .d_rd_en(d_rd_en),
      .d_rd_addr(d_rd_addr), .d_rd_data(d_q), .d_rd_cor(dc_q),
      .d_rd_unc(du_q), .done(done), .acc_err(acc_err), .prot_err(prot_err),
      .vstat(vstat), .flt_sgl(flt_sgl), .flt_dbl(flt_dbl)
   );

   // array model: one-cycle read latency, read counting at the edge
   always @(posedge clk) begin
      if (p_rd_en) begin
         p_q  <= p_mem[p_rd_addr];
         pc_q <= p_cor[p_rd_addr];
         pu_q <= p_unc[p_rd_addr];
         p_reads = p_reads + 1;
      end
      if (d_rd_en) begin
         d_q  <= d_mem[d_rd_addr];
         dc_q <= d_cor[d_rd_addr];
         du_q <= d_unc[d_rd_addr];
         d_reads = d_reads + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: pops expected results on each completion
   always @(negedge clk) begin
      if (rst_n) begin
         if (!done_q && done) begin
            if (expq.size() == 0) begin
               chk(1'b0, "R2", "unexpected completion", 1, 0);
            end else begin
               exp_t e;
               e = expq.pop_front();
               chk(vstat == e.vs, e.req, "vstat", vstat, e.vs);
               chk(p_reads - e.pb == e.pr, e.req, "program reads", p_reads - e.pb, e.pr);
               chk(d_reads - e.db == e.dr, e.req, "data reads", d_reads - e.db, e.dr);
            end
         end
         done_q = done;
      end
   end

   task automatic reg_wr(input logic [1:0] a, input logic [15:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic host_rd(input logic sel, input logic [3:0] a,
                          output logic vld, output logic [W-1:0] dat);
      @(negedge clk);
      h_rd_en = 1'b1; h_rd_sel = sel; h_rd_addr = a;
      @(negedge clk);
      vld = h_rd_valid; dat = h_rd_data;
      h_rd_en = 1'b0;
   endtask

   task automatic expect_run(input logic [1:0] vs, input int pr, input int dr,
                             input string req);
      exp_t e;
      e.vs = vs; e.pr = pr; e.dr = dr; e.pb = p_reads; e.db = d_reads; e.req = req;
      expq.push_back(e);
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!done && n < 1000) begin
         @(negedge clk);
         n++;
      end
      chk(done == 1'b1, req, "done timeout", done, 1);
      @(negedge clk);
   endtask

   task automatic load(input logic [7:0] op, input logic [1:0] gsel);
      reg_wr(2'd2, 16'h0000);
      reg_wr(2'd3, {op, 6'b0, gsel});
   endtask

   task automatic run_cmd(input logic [7:0] op, input logic [1:0] gsel,
                          input logic [1:0] vs, input int pr, input int dr,
                          input string req);
      load(op, gsel);
      expect_run(vs, pr, dr, req);
      reg_wr(2'd0, 16'h0080);
      wait_done(req);
   endtask

   task automatic reject(input string req);
      int pb, db;
      pb = p_reads; db = d_reads;
      reg_wr(2'd0, 16'h0080);
      chk(done == 1'b1, req, "done after rejected launch", done, 1);
      repeat (3) @(negedge clk);
      chk(p_reads == pb && d_reads == db, req, "reads after rejected launch",
          p_reads + d_reads - pb - db, 0);
   endtask

   task automatic finish_all();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_all();
   end

   initial begin
      logic vld;
      logic [W-1:0] dat;
      for (int i = 0; i < PW; i++) begin
         p_mem[i] = '1; p_cor[i] = 1'b0; p_unc[i] = 1'b0;
      end
      for (int i = 0; i < DWD; i++) begin
         d_mem[i] = '1; d_cor[i] = 1'b0; d_unc[i] = 1'b0;
      end
      p_q = '1; d_q = '1; pc_q = 0; pu_q = 0; dc_q = 0; du_q = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(done == 1'b1, "R1", "done", done, 1);
      chk({acc_err, prot_err} == 2'b00, "R1", "error flags", {acc_err, prot_err}, 0);
      chk(vstat == 2'b00, "R1", "vstat", vstat, 0);
      chk({flt_sgl, flt_dbl} == 2'b00, "R1", "fault flags", {flt_sgl, flt_dbl}, 0);

      // R2 R3 verify everything, all erased
      run_cmd(8'h01, 2'd0, 2'b00, PW, DWD, "R3");
      // R4 single region
      run_cmd(8'h02, 2'd0, 2'b00, PW, 0, "R4");
      run_cmd(8'h02, 2'd1, 2'b00, 0, DWD, "R4");

      // R4 bad region select
      load(8'h02, 2'd2);
      reject("R4");
      chk(acc_err == 1'b1, "R4", "acc_err on bad region", acc_err, 1);
      // R6 blocked while acc_err set, even with valid params
      load(8'h01, 2'd0);
      reject("R6");
      reg_wr(2'd0, 16'h0020);
      chk(acc_err == 1'b0, "R6", "acc_err write-one-clear", acc_err, 0);
      // R4 bad code
      load(8'h07, 2'd0);
      reject("R4");
      chk(acc_err == 1'b1, "R4", "acc_err on bad code", acc_err, 1);
      reg_wr(2'd0, 16'h0020);

      // R5 nonzero index
      load(8'h01, 2'd0);
      reg_wr(2'd2, 16'h0001);
      reject("R5");
      chk(acc_err == 1'b1, "R5", "acc_err on index", acc_err, 1);
      reg_wr(2'd0, 16'h0020);
      reg_wr(2'd2, 16'h0000);

      // R6 protection flag blocks a launch
      @(negedge clk); prot_set = 1'b1;
      @(negedge clk); prot_set = 1'b0;
      chk(prot_err == 1'b1, "R6", "prot_err set by input", prot_err, 1);
      reject("R6");
      reg_wr(2'd0, 16'h0010);
      chk(prot_err == 1'b0, "R6", "prot_err write-one-clear", prot_err, 0);

      // R8 correctable and uncorrectable reports
      p_cor[3] = 1'b1;
      run_cmd(8'h02, 2'd0, 2'b10, PW, 0, "R8");
      p_cor[3] = 1'b0;
      d_unc[2] = 1'b1;
      run_cmd(8'h02, 2'd1, 2'b11, 0, DWD, "R8");
      d_unc[2] = 1'b0;
      d_cor[7] = 1'b1;
      run_cmd(8'h01, 2'd0, 2'b10, PW, DWD, "R8");
      d_cor[7] = 1'b0;
      run_cmd(8'h01, 2'd0, 2'b00, PW, DWD, "R8");

      // R9 dirty word stops the scan
      p_mem[5] = 16'hFFFE;
      run_cmd(8'h01, 2'd0, 2'b11, 7, 0, "R9");
      p_mem[5] = '1;
      p_mem[PW-1] = 16'h7FFF;
      run_cmd(8'h01, 2'd0, 2'b11, PW, 0, "R9");
      p_mem[PW-1] = '1;
      d_mem[0] = 16'h0000;
      run_cmd(8'h02, 2'd1, 2'b11, 0, 2, "R9");
      d_mem[0] = '1;

      // R7 no command has set the protection flag
      chk(prot_err == 1'b0, "R7", "prot_err after commands", prot_err, 0);

      // R10 R11 host reads during a program-region scan
      d_mem[3] = 16'h1234;
      load(8'h02, 2'd0);
      expect_run(2'b00, PW, 1, "R10");
      reg_wr(2'd0, 16'h0080);
      host_rd(1'b0, 4'd2, vld, dat);
      chk(vld == 1'b1 && dat == '0, "R10", "colliding read data", dat, 0);
      chk(flt_sgl && flt_dbl, "R10", "both faults set", {flt_dbl, flt_sgl}, 3);
      host_rd(1'b1, 4'd3, vld, dat);
      chk(vld == 1'b1 && dat == 16'h1234, "R11", "idle region read", dat, 16'h1234);
      reg_wr(2'd1, 16'h0002);
      chk(flt_sgl == 1'b1 && flt_dbl == 1'b0, "R10", "clear double only",
          {flt_dbl, flt_sgl}, 1);
      host_rd(1'b0, 4'd4, vld, dat);
      chk(dat == '0, "R10", "second colliding read data", dat, 0);
      chk(flt_sgl == 1'b1 && flt_dbl == 1'b0, "R10", "faults unchanged when one set",
          {flt_dbl, flt_sgl}, 1);
      wait_done("R10");
      reg_wr(2'd1, 16'h0003);
      chk({flt_sgl, flt_dbl} == 2'b00, "R10", "faults cleared", {flt_sgl, flt_dbl}, 0);
      host_rd(1'b0, 4'd9, vld, dat);
      chk(vld == 1'b1 && dat == 16'hFFFF, "R11", "idle program read", dat, 16'hFFFF);
      d_mem[3] = '1;

      // R12 index and parameter writes ignored while busy
      load(8'h02, 2'd0);
      expect_run(2'b00, PW, 0, "R12");
      reg_wr(2'd0, 16'h0080);
      reg_wr(2'd2, 16'h0001);
      reg_wr(2'd3, 16'h0503);
      wait_done("R12");
      expect_run(2'b00, PW, 0, "R12");
      reg_wr(2'd0, 16'h0080);
      chk(done == 1'b0, "R12", "relaunch accepted", done, 0);
      wait_done("R12");
      chk(acc_err == 1'b0, "R12", "no access error after ignored writes", acc_err, 0);
      chk(expq.size() == 0, "R2", "pending expectations", expq.size(), 0);

      finish_all();
   end
endmodule